// File: doc/BRIEF.md
# Configuration Space Access Engine

This block turns a host request for one configuration register into the configuration cycles that a PCI-style bus master has to run. The host names a bus, a device slot, a function, a register byte offset and a transfer size of one, two or four bytes, and says whether the access is a read or a write. The engine decides how the target is addressed. A device on the local bus is selected through a one-hot select line in the upper address half. A device behind a bridge gets a forwarded address that carries the bus number. The engine then runs the cycle on its target port and waits for the acknowledge.

Two status registers inside the block collect the error bits that the target port reports with each acknowledge. After every cycle the engine tests a fixed set of error bits, clears only those, and turns a hit into an error flag. Read data is shifted so that the addressed byte lane sits at bit 0. An errored read returns all ones. A write narrower than a word becomes a read of the containing word, a lane merge and a write-back. If the read half of that sequence fails, the write-back is skipped and the request still completes.

Top module: `cfg_access_engine`

## Requirements
- R1: When the requested bus equals the local bus number (parameter, default 0), the target address has bit 0 clear, the device slot in bits [15:11], and a single set bit at position slot+16 (no select bit for slots 16 and above).
- R2: For any other bus, the target address carries the bus in bits [23:16], the slot in bits [15:11], bits [31:24] clear and bit 0 set.
- R3: Both address forms carry the function in bits [10:8] and the register offset in bits [7:2], with bit 1 always clear.
- R4: A successful read returns the fetched word shifted right by 8 times (offset mod 4), zero filled.
- R5: After each cycle, a request is flagged as errored only when a primary status bit in mask 0xF900 or a secondary status bit in mask 0x679F is set. Exactly those masked bits are cleared, so one error does not leak into later requests, and bits outside the masks never raise an error.
- R6: A read that sees an error completes with err high and rdata 0xFFFFFFFF.
- R7: A write with size code 2 or 3 (four bytes) runs exactly one write cycle carrying wdata unchanged. Write responses return rdata 0.
- R8: Size code 0 (one byte) and size code 1 (two bytes) writes read the word, replace the 8 or 16 bits that start at byte lane (offset mod 4) with the low bits of wdata, and write the word back to the same address. Lane bits that would fall above bit 31 are dropped.
- R9: If the read half of a partial write reports an error, no write cycle is run and the request completes with err high.
- R10: A request is taken when req_valid and req_ready are both high. From then until done, busy is high and req_ready is low. done is a one-cycle pulse, one per request.
- R11: The target request, address, data and write flag stay constant from the start of a cycle until the cycle in which tgt_ack is high.
- R12: After reset, busy, done and tgt_req are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Engine idle, able to take a request |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device slot |
| req_func | input | 3 | Target function |
| req_reg | input | 8 | Register byte offset |
| req_size | input | 2 | 0 one byte, 1 two bytes, 2 or 3 four bytes |
| req_write | input | 1 | 1 write, 0 read |
| req_wdata | input | 32 | Write value, right aligned |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| rdata | output | 32 | Aligned read data, valid with done |
| err | output | 1 | Error status, valid with done |
| tgt_req | output | 1 | Target cycle request |
| tgt_we | output | 1 | Target cycle is a write |
| tgt_addr | output | 32 | Configuration address |
| tgt_wdata | output | 32 | Target write word |
| tgt_ack | input | 1 | Target cycle complete |
| tgt_rdata | input | 32 | Target read word |
| tgt_pstat | input | 16 | Primary status bits raised by the cycle |
| tgt_sstat | input | 16 | Secondary status bits raised by the cycle |

## Verification
The bound checker watches the handshake on every cycle: acceptance raising busy, single-cycle done pulses, an idle target port outside requests and stable target signals while an acknowledge is pending. It also checks the shape of each address form, all-ones data on errored reads and the number of write cycles per request. It cannot tell whether the fields hold the right values or whether the merged word is correct. Those results come from the bench scenarios. They cover addresses checked against values computed from the request, data read back after partial writes in every lane, an unmasked status bit that must stay silent, a clean request right after an abort, and an aborted read-modify-write whose write must never appear at the responder.

// File: rtl/cfg_access_pkg.sv
package cfg_access_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CYC, ST_CHK} eng_state_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  // size codes 2 and 3 both mean a full word (R7)
  function automatic logic is_word(input logic [1:0] sz);
    return sz[1];
  endfunction
endpackage

// File: rtl/cfg_addr_build.sv
module cfg_addr_build #(
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FUNC_W    = 3,
  parameter int REG_W     = 8,
  parameter int ADDR_W    = 32,
  parameter int LOCAL_BUS = 0
) (
  input  logic [BUS_W-1:0]  bus,
  input  logic [DEV_W-1:0]  dev,
  input  logic [FUNC_W-1:0] func,
  input  logic [REG_W-1:0]  reg_off,
  output logic [ADDR_W-1:0] addr
);
  localparam int FUNC_LSB = 8;
  localparam int DEV_LSB  = 11;
  localparam int BUS_LSB  = 16;
  localparam int IDSEL_N  = ADDR_W - BUS_LSB;

  logic [ADDR_W-1:0] idsel;
  logic [ADDR_W-1:0] common;

  // one-hot select line for local-bus targets (R1)
  assign idsel[BUS_LSB-1:0] = '0;
  for (genvar i = 0; i < IDSEL_N; i++) begin : g_idsel
    assign idsel[BUS_LSB+i] = (32'(dev) == i);
  end

  // fields shared by both forms, dword-aligned offset (R3)
  assign common = (ADDR_W'(dev) << DEV_LSB) | (ADDR_W'(func) << FUNC_LSB) |
                  (ADDR_W'(reg_off) & ~ADDR_W'(3));

  always_comb begin
    if (32'(bus) == LOCAL_BUS) addr = common | idsel;
    else addr = common | (ADDR_W'(bus) << BUS_LSB) | ADDR_W'(1);  // R2
  end
endmodule

// File: rtl/cfg_lane_unit.sv
module cfg_lane_unit #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0]             word,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [$clog2(DATA_W/8)-1:0]   lane,
  input  logic [1:0]                    size,
  output logic [DATA_W-1:0]             aligned,
  output logic [DATA_W-1:0]             merged
);
  import cfg_access_pkg::*;
  localparam int NBYTES = DATA_W / 8;
  localparam int LW     = $clog2(NBYTES);

  logic [DATA_W-1:0] wsmall, shifted;
  logic [LW:0] lo, hi;

  // addressed byte lane moved to bit 0 (R4)
  assign aligned = word >> {lane, 3'b000};

  assign wsmall  = (size == SZ_BYTE) ? (wdata & DATA_W'(8'hFF)) : (wdata & DATA_W'(16'hFFFF));
  assign shifted = wsmall << {lane, 3'b000};
  assign lo      = {1'b0, lane};
  assign hi      = lo + ((size == SZ_BYTE) ? (LW+1)'(1) : (LW+1)'(2));

  // per-lane replace for read-modify-write (R8)
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic sel;
    assign sel = ((LW+1)'(b) >= lo) && ((LW+1)'(b) < hi);
    assign merged[8*b +: 8] = sel ? shifted[8*b +: 8] : word[8*b +: 8];
  end
endmodule

// File: rtl/cfg_status_unit.sv
module cfg_status_unit #(
  parameter int          STAT_W = 16,
  parameter logic [15:0] P_MASK = 16'hF900,
  parameter logic [15:0] S_MASK = 16'h679F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [STAT_W-1:0] p_in,
  input  logic [STAT_W-1:0] s_in,
  input  logic              clear,
  output logic              hit
);
  logic [STAT_W-1:0] p_q, s_q;
  localparam logic [STAT_W-1:0] PM = STAT_W'(P_MASK);
  localparam logic [STAT_W-1:0] SM = STAT_W'(S_MASK);

  // only masked bits count; only masked bits are cleared (R5)
  assign hit = (|(p_q & PM)) | (|(s_q & SM));

  always_ff @(posedge clk) begin
    if (rst) begin
      p_q <= '0;
      s_q <= '0;
    end else if (capture) begin
      p_q <= p_q | p_in;
      s_q <= s_q | s_in;
    end else if (clear) begin
      p_q <= p_q & ~PM;
      s_q <= s_q & ~SM;
    end
  end
endmodule

// File: rtl/cfg_access_engine.sv
module cfg_access_engine #(
  parameter int BUS_W     = 8,
  parameter int DEV_W     = 5,
  parameter int FUNC_W    = 3,
  parameter int REG_W     = 8,
  parameter int DATA_W    = 32,
  parameter int STAT_W    = 16,
  parameter int LOCAL_BUS = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [BUS_W-1:0]  req_bus,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic [FUNC_W-1:0] req_func,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  output logic              tgt_req,
  output logic              tgt_we,
  output logic [DATA_W-1:0] tgt_addr,
  output logic [DATA_W-1:0] tgt_wdata,
  input  logic              tgt_ack,
  input  logic [DATA_W-1:0] tgt_rdata,
  input  logic [STAT_W-1:0] tgt_pstat,
  input  logic [STAT_W-1:0] tgt_sstat
);
  import cfg_access_pkg::*;
  localparam int LW = $clog2(DATA_W/8);

  eng_state_t        state;
  logic              r_write;
  logic [1:0]        r_size;
  logic [LW-1:0]     r_lane;
  logic [DATA_W-1:0] r_wdata, word_q, addr_new, aligned, merged;
  logic              hit, accept, rmw_next;

  cfg_addr_build #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FUNC_W(FUNC_W), .REG_W(REG_W),
                   .ADDR_W(DATA_W), .LOCAL_BUS(LOCAL_BUS)) addr_i (
    .bus(req_bus), .dev(req_dev), .func(req_func), .reg_off(req_reg), .addr(addr_new));

  cfg_lane_unit #(.DATA_W(DATA_W)) lane_i (
    .word(word_q), .wdata(r_wdata), .lane(r_lane), .size(r_size),
    .aligned(aligned), .merged(merged));

  cfg_status_unit #(.STAT_W(STAT_W)) stat_i (
    .clk(clk), .rst(rst), .capture(state == ST_CYC && tgt_ack),
    .p_in(tgt_pstat), .s_in(tgt_sstat), .clear(state == ST_CHK), .hit(hit));

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign tgt_req   = (state == ST_CYC);
  assign accept    = req_valid && req_ready;
  // write-back only after a clean read half (R8, R9)
  assign rmw_next  = r_write && !is_word(r_size) && !tgt_we && !hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      err       <= 1'b0;
      rdata     <= '0;
      tgt_we    <= 1'b0;
      tgt_addr  <= '0;
      tgt_wdata <= '0;
      word_q    <= '0;
      r_write   <= 1'b0;
      r_size    <= '0;
      r_lane    <= '0;
      r_wdata   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          r_write   <= req_write;
          r_size    <= req_size;
          r_lane    <= req_reg[LW-1:0];
          r_wdata   <= req_wdata;
          tgt_addr  <= addr_new;
          tgt_we    <= req_write && is_word(req_size);  // R7
          tgt_wdata <= req_wdata;
          state     <= ST_CYC;
        end
        ST_CYC: if (tgt_ack) begin  // R11: outputs held until here
          word_q <= tgt_rdata;
          state  <= ST_CHK;
        end
        ST_CHK: if (rmw_next) begin
          tgt_wdata <= merged;
          tgt_we    <= 1'b1;
          state     <= ST_CYC;
        end else begin
          done  <= 1'b1;
          err   <= hit;
          rdata <= r_write ? '0 : (hit ? '1 : aligned);  // R4, R6
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_access_chk.sv
module cfg_access_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_size,
  input logic              req_write,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [DATA_W-1:0] rdata,
  input logic              tgt_req,
  input logic              tgt_we,
  input logic              tgt_ack,
  input logic [DATA_W-1:0] tgt_addr,
  input logic [DATA_W-1:0] tgt_wdata
);
  logic       last_wr, last_full;
  logic [3:0] wack;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_wr <= 1'b0; last_full <= 1'b0; wack <= '0;
    end else if (req_valid && req_ready) begin
      last_wr <= req_write; last_full <= req_size[1]; wack <= '0;
    end else if (tgt_req && tgt_ack && tgt_we) begin
      wack <= wack + 4'd1;
    end
  end

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> busy && !req_ready);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    tgt_req && !tgt_ack |=> tgt_req && $stable(tgt_addr) && $stable(tgt_we) && $stable(tgt_wdata));
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !tgt_req);
  assert_local_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    tgt_req && !tgt_addr[0] |-> $countones(tgt_addr[31:16]) <= 1);
  assert_remote_form_R2: assert property (@(posedge clk) disable iff (rst)
    tgt_req && tgt_addr[0] |-> tgt_addr[31:24] == 8'h00);
  assert_dword_offset_R3: assert property (@(posedge clk) disable iff (rst)
    tgt_req |-> !tgt_addr[1]);
  assert_read_ones_R6: assert property (@(posedge clk) disable iff (rst)
    done && err && !last_wr |-> rdata == '1);
  assert_word_write_once_R7: assert property (@(posedge clk) disable iff (rst)
    done && last_wr && last_full |-> wack == 4'd1);
  assert_read_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    done && !last_wr |-> wack == 4'd0);
endmodule

bind cfg_access_engine cfg_access_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_size(req_size), .req_write(req_write), .busy(busy), .done(done),
  .err(err), .rdata(rdata), .tgt_req(tgt_req), .tgt_we(tgt_we),
  .tgt_ack(tgt_ack), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata));

// File: tb/cfg_access_engine_tb_top.sv
module cfg_access_engine_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        req_valid = 1'b0, req_ready, req_write = 1'b0;
  logic [7:0]  req_bus = '0, req_reg = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_func = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0, rdata, tgt_addr, tgt_wdata;
  logic        busy, done, err, tgt_req, tgt_we;
  logic        tgt_ack = 1'b0;
  logic [31:0] tgt_rdata = '0;
  logic [15:0] tgt_pstat = '0, tgt_sstat = '0;

  cfg_access_engine dut_i (.*);

  typedef struct { logic [31:0] rd; logic er; string tag; } exp_t;
  exp_t        sq[$];
  logic [31:0] aq[$];
  logic [31:0] rmem[int];
  logic [31:0] smem[int];
  int n_cmp = 0, n_bad = 0, wr_count = 0, lat = 0, wait_cnt = 0;
  int done_count = 0, sent = 0;
  bit finished = 0;

  function automatic int key(input int bus, input int slot, input int func, input int dw);
    return (bus << 14) | (slot << 9) | (func << 6) | dw;
  endfunction
  function automatic logic [31:0] init_word(input int k);
    return (32'(k) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction
  function automatic bit present(input int bus, input int slot);
    return (bus == 0 && (slot == 1 || slot == 3 || slot == 7)) || (bus == 2 && slot == 5);
  endfunction
  function automatic bit poison(input int bus, input int slot, input int dw);
    return bus == 0 && slot == 7 && dw == 4;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural target: acts on negative edges, never at the active edge
  always @(negedge clk) begin
    if (rst) begin
      tgt_ack = 0; tgt_pstat = 0; tgt_sstat = 0; wait_cnt = 0;
    end else if (tgt_ack) begin
      tgt_ack = 0; tgt_pstat = 0; tgt_sstat = 0;
    end else if (tgt_req) begin
      if (wait_cnt < lat) wait_cnt++;
      else begin
        int bus, slot, k;
        wait_cnt = 0;
        if (aq.size() == 0) check("R9 unexpected target cycle", tgt_addr, 32'hDEADDEAD);
        else check(tgt_addr[0] ? "R2 R3 address" : "R1 R3 address", tgt_addr, aq.pop_front());
        bus  = tgt_addr[0] ? int'(tgt_addr[23:16]) : 0;
        slot = int'(tgt_addr[15:11]);
        k    = key(bus, slot, int'(tgt_addr[10:8]), int'(tgt_addr[7:2]));
        tgt_rdata = 32'hFFFFFFFF;
        if (!present(bus, slot)) begin
          tgt_pstat = 16'h2000; tgt_sstat = 16'h0008;  // master abort
        end else begin
          if (tgt_we) begin rmem[k] = tgt_wdata; wr_count++; end
          else tgt_rdata = rmem.exists(k) ? rmem[k] : init_word(k);
          tgt_pstat = (bus == 0 && slot == 3) ? 16'h0001 : 16'h0000;  // outside mask
          tgt_sstat = poison(bus, slot, int'(tgt_addr[7:2])) ? 16'h0080 : 16'h0000;
        end
        tgt_ack = 1;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      done_count++;
      if (sq.size() == 0) check("R10 extra done", 32'h1, 32'h0);
      else begin
        exp_t e;
        e = sq.pop_front();
        check({e.tag, " rdata"}, rdata, e.rd);
        check({e.tag, " err"}, 32'(err), 32'(e.er));
      end
    end
  end

  task automatic send(input int bus, input int dev, input int func, input int rg,
                      input int size, input bit wr, input logic [31:0] wd, input string tag);
    logic [63:0] a;
    logic [31:0] cur, msk, nw;
    int k, sh;
    bit bad;
    exp_t e;
    a = (64'(dev) << 11) | (64'(func) << 8) | 64'(rg & 32'hFC);
    if (bus != 0) a = a | (64'(bus) << 16) | 64'd1;
    else a = a | (64'd1 << (dev + 16));
    k   = key(bus, dev, func, rg >> 2);
    bad = !present(bus, dev) || poison(bus, dev, rg >> 2);
    cur = smem.exists(k) ? smem[k] : init_word(k);
    sh  = 8 * (rg % 4);
    e.tag = tag; e.rd = '0;
    aq.push_back(a[31:0]);
    if (!wr) begin
      e.er = bad; e.rd = bad ? 32'hFFFFFFFF : (cur >> sh);
    end else if (size >= 2) begin
      e.er = bad; if (!bad) smem[k] = wd;
    end else if (bad) begin
      e.er = 1;
    end else begin
      aq.push_back(a[31:0]);
      msk = (size == 0) ? 32'hFF : 32'hFFFF;
      nw  = (cur & ~(msk << sh)) | ((wd & msk) << sh);
      smem[k] = nw; e.er = 0;
    end
    sq.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_bus = 8'(bus); req_dev = 5'(dev); req_func = 3'(func); req_reg = 8'(rg);
    req_size = 2'(size); req_write = wr; req_wdata = wd; req_valid = 1;
    sent++;
    @(negedge clk);
    req_valid = 0;
    check("R10 busy after accept", {busy, req_ready}, 2'b10);
    while (busy) @(negedge clk);
  endtask

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    check("R12 reset outputs", {busy, done, tgt_req, req_ready}, 4'b0001);
    rst = 0;
    @(negedge clk);
    check("R12 idle after reset", {busy, done, tgt_req, req_ready}, 4'b0001);
    // R1 R4: local bus reads in every lane
    for (int i = 0; i < 4; i++) send(0, 1, i, 8'h08 + i, 2, 0, 0, "R4 lane read");
    send(0, 1, 6, 8'hFF, 2, 0, 0, "R3 top offset");
    // R5: unmasked primary bit stays silent
    send(0, 3, 0, 8'h00, 2, 0, 0, "R5 unmasked bit");
    // R6 then R5: abort, followed by clean read
    send(0, 9, 0, 8'h10, 2, 0, 0, "R6 absent read");
    send(0, 1, 0, 8'h10, 2, 0, 0, "R5 cleared after abort");
    send(0, 20, 1, 8'h04, 2, 0, 0, "R1 slot above select range");
    // R2: forwarded bus
    send(2, 5, 3, 8'h3D, 2, 0, 0, "R2 remote read");
    send(4, 0, 0, 8'h00, 2, 0, 0, "R6 remote absent");
    // R7: word write, read back
    begin
      int w0;
      w0 = wr_count;
      send(0, 1, 2, 8'h20, 2, 1, 32'hCAFE_F00D, "R7 word write");
      check("R7 one write cycle", 32'(wr_count - w0), 32'd1);
    end
    send(0, 1, 2, 8'h20, 3, 1, 32'h1234_5678, "R7 size three write");
    send(0, 1, 2, 8'h20, 2, 0, 0, "R7 readback");
    // R8: byte and half merges, read back whole word
    for (int i = 0; i < 4; i++) begin
      int w0;
      w0 = wr_count;
      send(0, 1, 0, 8'h30 + i, 0, 1, 32'hFFFF_FF00 | i, "R8 byte merge");
      check("R8 write-back ran", 32'(wr_count - w0), 32'd1);
      send(0, 1, 0, 8'h30, 2, 0, 0, "R8 byte readback");
    end
    send(2, 5, 1, 8'h40, 1, 1, 32'hAAAA_BEEF, "R8 half lane0");
    send(2, 5, 1, 8'h42, 1, 1, 32'h0000_1357, "R8 half lane2");
    send(2, 5, 1, 8'h43, 1, 1, 32'h0000_9AC4, "R8 half lane3");
    send(2, 5, 1, 8'h40, 2, 0, 0, "R8 half readback");
    // R9: read half fails, write dropped
    begin
      int w0;
      w0 = wr_count;
      send(0, 7, 0, 8'h11, 0, 1, 32'h55, "R9 poisoned merge");
      send(0, 9, 2, 8'h02, 1, 1, 32'h77, "R9 absent merge");
      check("R9 no write cycle", 32'(wr_count - w0), 32'd0);
    end
    send(0, 7, 0, 8'h12, 2, 0, 0, "R5 secondary mask read");
    send(0, 7, 0, 8'h08, 2, 0, 0, "R5 parity device clean");
    // R11: slow target
    lat = 3;
    send(0, 3, 1, 8'h05, 0, 1, 32'hA1, "R11 slow merge");
    send(0, 3, 1, 8'h04, 2, 0, 0, "R11 slow readback");
    send(2, 5, 0, 8'h00, 2, 1, 32'h0BAD_C0DE, "R11 slow word write");
    lat = 0;
    repeat (3) @(negedge clk);
    check("R10 one done per request", 32'(done_count), 32'(sent));
    check("R9 no pending address", 32'(aq.size()), 32'd0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R10 watchdog: actual hung expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule